// File: doc/BRIEF.md
# Vector-to-Scalar Micro-op Expander

This front-end stage accepts one decoded 48-bit instruction at a time. Each of its three register specifiers (one destination, two sources) has a flag bit that marks it as a vector register. An instruction with any flagged specifier is split into a run of scalar micro-ops. The run has one micro-op per active element, and its length comes from the vector length that applies when the instruction is accepted. An instruction with no flagged specifier leaves as a single micro-op.

All specifiers are rewritten into one flat 8-bit register index space that scalar and vector operands share. A scalar register number is used as the flat index unchanged. A vector register's elements take eight consecutive flat indices starting at the vector number times eight, so the 64 scalar registers overlap the first eight vector registers. Each micro-op carries its element number and a flag that marks the last copy.

Both sides use valid/ready handshakes. A synchronous flush drops any expansion that is in progress.

Top module: `vec_uop_expander`

## Requirements
- R1: After reset, `outValid` is low and `inReady` is high.
- R2: The instruction word has this layout. The destination specifier is bits [5:0], source A is bits [11:6] and source B is bits [17:12]. Their vector flags are bits 18, 19 and 20. Bits [47:21] are payload. An instruction with all three flags clear produces exactly one micro-op with element 0 and the last flag set. In that micro-op each specifier is zero-extended to 8 bits, the payload is unchanged, and `vecLen` has no effect.
- R3: A flagged specifier in copy k produces the flat index {spec[4:0], k[2:0]}, which is base*8+k. Bit 5 of a flagged specifier has no effect on the output.
- R4: An unflagged specifier produces the same zero-extended flat index in every copy of a vector instruction.
- R5: A vector instruction produces N copies with element indices 0 to N-1 in order. N is `vecLen` for values 1 to 8, 1 when `vecLen` is 0, and 8 when `vecLen` is above 8. Only copy N-1 has the last flag set. Each accepted copy advances the element index by one.
- R6: `inReady` is low while copies other than the last remain. When the last copy is accepted, a new instruction can be accepted in the same cycle, and its first copy appears in the next cycle.
- R7: While `outValid` is high and `outReady` is low, the presented micro-op stays unchanged.
- R8: When `flush` is high, `inReady` is low in that cycle, and in the next cycle `outValid` is low with the expansion discarded.
- R9: `vecLen` is sampled only when an instruction is accepted. Changes to it during an expansion do not change the copy count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard current expansion |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Instruction can be accepted |
| instrIn | input | 48 | Decoded instruction word |
| vecLen | input | 4 | Current vector length |
| outValid | output | 1 | Micro-op presented |
| outReady | input | 1 | Downstream accepts micro-op |
| uopPayload | output | 27 | Unchanged instruction payload bits |
| uopDst | output | 8 | Flat destination index |
| uopSrcA | output | 8 | Flat source A index |
| uopSrcB | output | 8 | Flat source B index |
| uopElem | output | 3 | Element number of this copy |
| uopLast | output | 1 | Final copy of the instruction |

## Verification
Assertions check four things on every cycle. Input acceptance stays blocked while copies remain. A stalled micro-op keeps its element index. The element index steps by exactly one per accepted non-final copy. A flush leaves the stage idle in the following cycle. Only the bench scenarios can show the following behaviours. They cover the copy count for each length, including the clamped and zero cases, and the flat-index arithmetic with the unused base bit. They also cover the payload pass-through, sampling of the length at acceptance, and the back-to-back hand-off between instructions.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  // Operand order inside the word: destination, source A, source B.
  localparam int NUM_OPS = 3;

  typedef struct packed {
    logic load;   // capture a new instruction
    logic clear;  // flush in progress
  } vexp_strobe_t;
endpackage

// File: rtl/vexp_dpath.sv
module vexp_dpath
  import vexp_pkg::*;
#(
  parameter int INSTR_W   = 48,
  parameter int SPEC_W    = 6,
  parameter int FLAT_W    = 8,
  parameter int NUM_ELEMS = 8,
  parameter int VLEN_W    = 4,
  localparam int ELEM_W   = $clog2(NUM_ELEMS),
  localparam int FLAG_LSB = NUM_OPS * SPEC_W,
  localparam int PAY_W    = INSTR_W - FLAG_LSB - NUM_OPS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vexp_strobe_t         stb,
  input  logic [INSTR_W-1:0]   instrIn,
  input  logic [VLEN_W-1:0]    vecLen,
  input  logic [ELEM_W-1:0]    elemIdx,
  output logic [ELEM_W-1:0]    lastIdx,
  output logic [PAY_W-1:0]     uopPayload,
  output logic [FLAT_W-1:0]    uopDst,
  output logic [FLAT_W-1:0]    uopSrcA,
  output logic [FLAT_W-1:0]    uopSrcB
);
  localparam int BASE_W = FLAT_W - ELEM_W;

  logic [INSTR_W-1:0] heldInstr;
  logic [ELEM_W-1:0]  lastNext;
  logic               anyVec;
  logic [FLAT_W-1:0]  flat [NUM_OPS];

  assign anyVec = |instrIn[FLAG_LSB +: NUM_OPS];

  // Copy count from the length in force at acceptance: 0 -> 1, over max -> max.
  always_comb begin
    if (!anyVec || vecLen == '0)
      lastNext = '0;
    else if (int'(vecLen) >= NUM_ELEMS)
      lastNext = ELEM_W'(NUM_ELEMS - 1);
    else
      lastNext = ELEM_W'(vecLen - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldInstr <= '0;
      lastIdx   <= '0;
    end else if (stb.clear) begin
      lastIdx   <= '0;
    end else if (stb.load) begin
      heldInstr <= instrIn;
      lastIdx   <= lastNext;
    end
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic [SPEC_W-1:0] spec;
    logic              isVec;
    assign spec  = heldInstr[i*SPEC_W +: SPEC_W];
    assign isVec = heldInstr[FLAG_LSB + i];
    assign flat[i] = isVec ? {spec[BASE_W-1:0], elemIdx} : FLAT_W'(spec);
  end

  assign uopDst     = flat[0];
  assign uopSrcA    = flat[1];
  assign uopSrcB    = flat[2];
  assign uopPayload = heldInstr[INSTR_W-1 -: PAY_W];
endmodule

// File: rtl/vexp_ctrl.sv
module vexp_ctrl
  import vexp_pkg::*;
#(
  parameter int NUM_ELEMS = 8,
  localparam int ELEM_W   = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  input  logic [ELEM_W-1:0] lastIdx,
  output logic [ELEM_W-1:0] elemIdx,
  output logic              isLast,
  output vexp_strobe_t      stb
);
  logic busy;
  logic fire;

  assign isLast    = elemIdx == lastIdx;
  assign fire      = busy && outReady;
  assign inReady   = !flush && (!busy || (outReady && isLast));
  assign stb.load  = inValid && inReady;
  assign stb.clear = flush;
  assign outValid  = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      elemIdx <= '0;
    end else if (flush) begin
      busy    <= 1'b0;
      elemIdx <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      elemIdx <= '0;
    end else if (fire && isLast) begin
      busy    <= 1'b0;
      elemIdx <= '0;
    end else if (fire) begin
      elemIdx <= elemIdx + 1'b1;
    end
  end

  a_r6_hold_in_ready: assert property (@(posedge clk) disable iff (!rstN)
    busy && !isLast |-> !inReady);

  a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rstN)
    busy && !outReady && !flush |=> busy && $stable(elemIdx));

  a_r8_flush_idle: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !outValid);

  a_r5_elem_step: assert property (@(posedge clk) disable iff (!rstN)
    busy && outReady && !isLast && !flush |=> elemIdx == ELEM_W'($past(elemIdx) + 1'b1));
endmodule

// File: rtl/vec_uop_expander.sv
module vec_uop_expander
  import vexp_pkg::*;
#(
  parameter int INSTR_W   = 48,
  parameter int SPEC_W    = 6,
  parameter int FLAT_W    = 8,
  parameter int NUM_ELEMS = 8,
  parameter int VLEN_W    = 4,
  localparam int ELEM_W   = $clog2(NUM_ELEMS),
  localparam int PAY_W    = INSTR_W - NUM_OPS * SPEC_W - NUM_OPS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               inValid,
  output logic               inReady,
  input  logic [INSTR_W-1:0] instrIn,
  input  logic [VLEN_W-1:0]  vecLen,
  output logic               outValid,
  input  logic               outReady,
  output logic [PAY_W-1:0]   uopPayload,
  output logic [FLAT_W-1:0]  uopDst,
  output logic [FLAT_W-1:0]  uopSrcA,
  output logic [FLAT_W-1:0]  uopSrcB,
  output logic [ELEM_W-1:0]  uopElem,
  output logic               uopLast
);
  vexp_strobe_t      stb;
  logic [ELEM_W-1:0] lastIdx;

  vexp_ctrl #(.NUM_ELEMS(NUM_ELEMS)) u_ctrl (
    .clk, .rstN, .flush, .inValid, .inReady, .outValid, .outReady,
    .lastIdx, .elemIdx(uopElem), .isLast(uopLast), .stb
  );

  vexp_dpath #(
    .INSTR_W(INSTR_W), .SPEC_W(SPEC_W), .FLAT_W(FLAT_W),
    .NUM_ELEMS(NUM_ELEMS), .VLEN_W(VLEN_W)
  ) u_dpath (
    .clk, .rstN, .stb, .instrIn, .vecLen, .elemIdx(uopElem), .lastIdx,
    .uopPayload, .uopDst, .uopSrcA, .uopSrcB
  );
endmodule

// File: tb/vec_uop_expander_tb.sv
`timescale 1ns/1ps
module vec_uop_expander_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [47:0] instrIn = '0;
  logic [3:0]  vecLen = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [26:0] uopPayload;
  logic [7:0]  uopDst, uopSrcA, uopSrcB;
  logic [2:0]  uopElem;
  logic        uopLast;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_uop_expander u_dut (
    .clk, .rstN, .flush, .inValid, .inReady, .instrIn, .vecLen,
    .outValid, .outReady, .uopPayload, .uopDst, .uopSrcA, .uopSrcB,
    .uopElem, .uopLast
  );

  // Entry: {payload[26:0], flags{B,A,D}[2:0], srcB[5:0], srcA[5:0], dst[5:0], vecLen[3:0]}
  localparam logic [51:0] TABLE [8] = '{
    {27'h0123456, 3'b000, 6'd63, 6'd17, 6'd5,  4'd5},
    {27'h7654321, 3'b001, 6'd2,  6'd3,  6'd9,  4'd8},
    {27'h0abcdef, 3'b111, 6'd31, 6'd1,  6'd4,  4'd3},
    {27'h1111111, 3'b010, 6'd40, 6'd7,  6'd12, 4'd0},
    {27'h2222222, 3'b100, 6'd6,  6'd44, 6'd13, 4'd12},
    {27'h3333333, 3'b011, 6'd8,  6'd10, 6'd20, 4'd1},
    {27'h4444444, 3'b101, 6'h25, 6'd33, 6'h3f, 4'd8},
    {27'h5555555, 3'b110, 6'd29, 6'd30, 6'd50, 4'd15}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flatOf(logic [5:0] spec, logic isVec, int k);
    return isVec ? {spec[4:0], 3'(k)} : {2'b00, spec};
  endfunction

  function automatic int copiesOf(logic [2:0] flags, logic [3:0] vl);
    if (flags == 3'b000 || vl == 0) return 1;
    if (vl > 8) return 8;
    return int'(vl);
  endfunction

  // Check the micro-op currently presented as copy k of n.
  task automatic checkUop(string req, logic [47:0] ins, int k, int n);
    check({req, " valid"}, 64'(outValid), 64'd1);
    check({req, " elem"},  64'(uopElem), 64'(k));
    check({req, " last"},  64'(uopLast), 64'(k == n - 1));
    check({req, " dst"},   64'(uopDst),  64'(flatOf(ins[5:0],   ins[18], k)));
    check({req, " srcA"},  64'(uopSrcA), 64'(flatOf(ins[11:6],  ins[19], k)));
    check({req, " srcB"},  64'(uopSrcB), 64'(flatOf(ins[17:12], ins[20], k)));
    check({req, " payload"}, 64'(uopPayload), 64'(ins[47:21]));
  endtask

  // Offer one instruction from idle and drain it with outReady high.
  task automatic runInstr(string req, logic [47:0] ins, logic [3:0] vl);
    int n;
    n = copiesOf(ins[20:18], vl);
    @(negedge clk);
    outReady = 1'b1;
    check({req, " inReady idle"}, 64'(inReady), 64'd1);
    inValid = 1'b1; instrIn = ins; vecLen = vl;
    @(negedge clk);
    inValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      checkUop(req, ins, k, n);
      @(negedge clk);
    end
    check({req, " drained"}, 64'(outValid), 64'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [47:0] ins;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 outValid", 64'(outValid), 64'd0);
    check("R1 inReady",  64'(inReady),  64'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after release", 64'(outValid), 64'd0);

    // Table walk: R2 scalar, R3 vector index, R4 unflagged, R5 counts and clamp
    for (int i = 0; i < 8; i++) begin
      runInstr($sformatf("R2/R3/R4/R5 entry%0d", i), TABLE[i][51:4], TABLE[i][3:0]);
    end

    // R7: stall holds the micro-op; R6: inReady low mid-expansion
    ins = {27'h00000aa, 3'b111, 6'd3, 6'd2, 6'd1};
    @(negedge clk);
    outReady = 1'b0; inValid = 1'b1; instrIn = ins; vecLen = 4'd4;
    @(negedge clk);
    inValid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      checkUop("R7 stall", ins, 0, 4);
      check("R6 inReady low", 64'(inReady), 64'd0);
      @(negedge clk);
    end
    outReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      checkUop("R7 resume", ins, k, 4);
      @(negedge clk);
    end

    // R6: back-to-back hand-off on the last copy
    ins = {27'h00000bb, 3'b001, 6'd0, 6'd0, 6'd7};
    inValid = 1'b1; instrIn = ins; vecLen = 4'd2;
    @(negedge clk);
    inValid = 1'b0;
    checkUop("R6 first", ins, 0, 2);
    check("R6 inReady low before last", 64'(inReady), 64'd0);
    @(negedge clk);
    checkUop("R6 last", ins, 1, 2);
    check("R6 inReady on last", 64'(inReady), 64'd1);
    ins = {27'h00000cc, 3'b000, 6'd9, 6'd8, 6'd7};
    inValid = 1'b1; instrIn = ins; vecLen = 4'd6;
    @(negedge clk);
    inValid = 1'b0;
    checkUop("R6 next instr", ins, 0, 1);
    @(negedge clk);
    check("R6 drained", 64'(outValid), 64'd0);

    // R9: length changed after acceptance has no effect
    ins = {27'h00000dd, 3'b010, 6'd0, 6'd11, 6'd0};
    inValid = 1'b1; instrIn = ins; vecLen = 4'd3;
    @(negedge clk);
    inValid = 1'b0; vecLen = 4'd8;
    for (int k = 0; k < 3; k++) begin
      checkUop("R9 sampled length", ins, k, 3);
      @(negedge clk);
    end
    check("R9 count", 64'(outValid), 64'd0);

    // R8: flush mid-expansion
    ins = {27'h00000ee, 3'b001, 6'd0, 6'd0, 6'd2};
    inValid = 1'b1; instrIn = ins; vecLen = 4'd8;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkUop("R8 before flush", ins, 1, 8);
    flush = 1'b1; inValid = 1'b1; instrIn = {27'h1, 3'b000, 18'h0};
    #0.1;
    check("R8 inReady during flush", 64'(inReady), 64'd0);
    @(negedge clk);
    flush = 1'b0; inValid = 1'b0;
    check("R8 outValid after flush", 64'(outValid), 64'd0);
    @(negedge clk);
    check("R8 stays idle", 64'(outValid), 64'd0);
    runInstr("R8 after flush", {27'h0000fff, 3'b100, 6'd4, 6'd5, 6'd6}, 4'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule